// File: doc/BRIEF.md
# Sleep and Standby Power Controller

This block manages the low-power modes of a small processor core. When the CPU signals that it has executed its sleep instruction, the controller looks at a software-written mode-select bit. With the bit clear it enters a light sleep: only the CPU clock is stopped and the peripherals keep running. With the bit set it enters a deep standby: the CPU clock and every peripheral clock are stopped, and a one-cycle initialize pulse goes to the peripherals that lose their state in that mode. CPU register contents are never touched.

While the core is halted, the controller watches the wake sources and decides whether to leave the mode. In light sleep an interrupt counts only if its priority is strictly above the CPU mask level and the source is enabled. A DMA address error also counts, and so does NMI. In deep standby only NMI or a reset can wake the core, and an NMI exit first waits a programmable settling time before the clocks come back. NMI is ignored during a short fixed window that starts with the sleep strobe. Every exit through a wake source produces a single-cycle wake request with a cause code for the exception logic.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: In the run state, a sleep strobe with stby_sel at 0 enters sleep. From the next cycle cpu_clk_en is 0 and per_clk_en stays 1.
- R2: In the run state, a sleep strobe with stby_sel at 1 enters standby. From the next cycle cpu_clk_en and per_clk_en are both 0, and per_init is 1 for exactly that first standby cycle.
- R3: In sleep, an interrupt wakes the core only when irq_req=1, irq_src_en=1 and irq_level > cpu_mask (unsigned). On the following cycle cpu_clk_en is 1 and wake_req pulses with wake_cause 2'b00. An equal or lower level, or a disabled source, leaves the controller asleep.
- R4: In sleep, dma_addr_err wakes the core with wake_cause 2'b01. When several sources arrive in the same cycle, NMI (2'b10) wins over the DMA address error, and the DMA address error wins over an interrupt.
- R5: NMI is ignored in the cycle of an accepted sleep strobe and in the five cycles that follow. An NMI in the sixth cycle after the strobe is accepted. In sleep it wakes the core with wake_cause 2'b10.
- R6: In standby, interrupts and DMA address errors have no effect. The clocks stay off and no wake request is issued.
- R7: In standby, an accepted NMI starts a settling wait of 2^k cycles, where k is settle_exp clamped to the range 3..12. After the wait, cpu_clk_en and per_clk_en return to 1 and wake_req pulses with wake_cause 2'b10.
- R8: mrst during sleep, standby or the settling wait returns the controller to run on the next cycle with a wake_req pulse of cause 2'b11, and it keeps stby_sel. mrst in the run state issues no wake request.
- R9: por (synchronous, active high) forces the run state with both clock enables at 1, stby_sel at 0, and wake_req and per_init at 0.
- R10: wake_req is never high in two consecutive cycles. cpu_clk_en is never 1 while per_clk_en is 0.
- R11: sel_we=1 loads sel_wd into the mode-select bit, which shows on stby_sel from the next cycle.
- R12: A sleep strobe that arrives while the controller is already in a low-power state is ignored. The mode does not change and no per_init pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| mrst | input | 1 | Manual reset request |
| sleep_stb | input | 1 | One-cycle strobe from the CPU when the sleep instruction executes |
| sel_we | input | 1 | Write enable for the mode-select bit |
| sel_wd | input | 1 | Write data for the mode-select bit (1 = standby) |
| irq_req | input | 1 | Pending interrupt from the interrupt controller |
| irq_level | input | LVL_W | Priority level of the pending interrupt |
| cpu_mask | input | LVL_W | CPU interrupt mask level |
| irq_src_en | input | 1 | Interrupt enabled at its source |
| dma_addr_err | input | 1 | DMA address error |
| nmi | input | 1 | Non-maskable interrupt request |
| settle_exp | input | EXP_W | Settling-time exponent, clamped to 3..12 |
| stby_sel | output | 1 | Current mode-select bit |
| cpu_clk_en | output | 1 | Registered CPU clock enable |
| per_clk_en | output | 1 | Registered peripheral clock enable |
| per_init | output | 1 | One-cycle initialize pulse on standby entry |
| wake_req | output | 1 | One-cycle wake request |
| wake_cause | output | 2 | Wake cause: 00 interrupt, 01 DMA address error, 10 NMI, 11 reset |

## Verification
The properties assume that por is high at the first clock edge, so that every register has a defined value before any check starts. They also assume that all inputs are synchronous to clk. The interrupt-masking and standby-hold properties hold only when no stronger source (NMI, DMA address error, mrst) is active in the same cycle. The stimulus respects this by driving inputs only between clock edges and by sending random trials for a wake source only after the five-cycle NMI blanking window has passed. The bench computes the expected outcome of each trial from the chosen source combination, so simultaneous sources are handled by the priority order of R4 and not by excluding them.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        PM_RUN    = 2'b00,
        PM_SLEEP  = 2'b01,
        PM_STBY   = 2'b10,
        PM_SETTLE = 2'b11
    } pm_state_e;

    typedef enum logic [1:0] {
        WK_IRQ    = 2'b00,
        WK_DMAERR = 2'b01,
        WK_NMI    = 2'b10,
        WK_RESET  = 2'b11
    } wake_cause_e;

    typedef struct packed {
        logic        hit;
        wake_cause_e cause;
    } wake_ev_t;

    function automatic int unsigned clamp_exp(input int unsigned e,
                                              input int unsigned lo,
                                              input int unsigned hi);
        if (e < lo) return lo;
        if (e > hi) return hi;
        return e;
    endfunction

endpackage

// File: rtl/pwr_nmi_blank.sv
module pwr_nmi_blank #(
    parameter int BLANK_CYC = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic nmi_in,
    output logic nmi_ok
);
    localparam int CW = $clog2(BLANK_CYC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (arm) begin
            cnt_q <= CW'(BLANK_CYC);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // strobe cycle blanked combinationally, following cycles by the counter
    assign nmi_ok = nmi_in && !arm && (cnt_q == '0);
endmodule

// File: rtl/pwr_wake_qual.sv
module pwr_wake_qual
    import pwr_mode_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input  logic             in_sleep,
    input  logic             in_stby,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [LVL_W-1:0] cpu_mask,
    input  logic             irq_src_en,
    input  logic             dma_addr_err,
    input  logic             nmi_ok,
    output wake_ev_t         ev
);
    logic irq_ok;

    assign irq_ok = irq_req && irq_src_en && (irq_level > cpu_mask);

    always_comb begin
        ev.hit   = 1'b0;
        ev.cause = WK_IRQ;
        if (in_stby) begin
            if (nmi_ok) begin
                ev.hit   = 1'b1;
                ev.cause = WK_NMI;
            end
        end else if (in_sleep) begin
            if (nmi_ok) begin
                ev.hit   = 1'b1;
                ev.cause = WK_NMI;
            end else if (dma_addr_err) begin
                ev.hit   = 1'b1;
                ev.cause = WK_DMAERR;
            end else if (irq_ok) begin
                ev.hit   = 1'b1;
                ev.cause = WK_IRQ;
            end
        end
    end
endmodule

// File: rtl/pwr_settle_timer.sv
module pwr_settle_timer
    import pwr_mode_pkg::*;
#(
    parameter int EXP_W   = 4,
    parameter int MIN_EXP = 3,
    parameter int MAX_EXP = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             done
);
    localparam int CNT_W = MAX_EXP;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ld_val;

    always_comb begin
        ld_val = CNT_W'((64'd1 << clamp_exp(32'(exp_sel), MIN_EXP, MAX_EXP)) - 64'd1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= ld_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int LVL_W     = 4,
    parameter int BLANK_CYC = 5,
    parameter int EXP_W     = 4,
    parameter int MIN_EXP   = 3,
    parameter int MAX_EXP   = 12
) (
    input  logic             clk,
    input  logic             por,
    input  logic             mrst,
    input  logic             sleep_stb,
    input  logic             sel_we,
    input  logic             sel_wd,
    input  logic             irq_req,
    input  logic [LVL_W-1:0] irq_level,
    input  logic [LVL_W-1:0] cpu_mask,
    input  logic             irq_src_en,
    input  logic             dma_addr_err,
    input  logic             nmi,
    input  logic [EXP_W-1:0] settle_exp,
    output logic             stby_sel,
    output logic             cpu_clk_en,
    output logic             per_clk_en,
    output logic             per_init,
    output logic             wake_req,
    output logic [1:0]       wake_cause
);
    pm_state_e   st_q, st_n;
    wake_cause_e cause_q, cause_n;
    logic        sel_q;
    logic        wake_n;
    logic        arm, nmi_ok, settle_done, settle_load;
    wake_ev_t    ev;

    assign arm = (st_q == PM_RUN) && sleep_stb && !mrst;

    pwr_nmi_blank #(.BLANK_CYC(BLANK_CYC)) u_blank (
        .clk    (clk),
        .rst    (por),
        .arm    (arm),
        .nmi_in (nmi),
        .nmi_ok (nmi_ok)
    );

    pwr_wake_qual #(.LVL_W(LVL_W)) u_qual (
        .in_sleep     (st_q == PM_SLEEP),
        .in_stby      (st_q == PM_STBY),
        .irq_req      (irq_req),
        .irq_level    (irq_level),
        .cpu_mask     (cpu_mask),
        .irq_src_en   (irq_src_en),
        .dma_addr_err (dma_addr_err),
        .nmi_ok       (nmi_ok),
        .ev           (ev)
    );

    assign settle_load = (st_q == PM_STBY) && ev.hit && !mrst;

    pwr_settle_timer #(
        .EXP_W   (EXP_W),
        .MIN_EXP (MIN_EXP),
        .MAX_EXP (MAX_EXP)
    ) u_settle (
        .clk     (clk),
        .rst     (por),
        .load    (settle_load),
        .exp_sel (settle_exp),
        .done    (settle_done)
    );

    always_comb begin
        st_n    = st_q;
        wake_n  = 1'b0;
        cause_n = cause_q;
        if (mrst) begin
            st_n = PM_RUN;
            if (st_q != PM_RUN) begin
                wake_n  = 1'b1;
                cause_n = WK_RESET;
            end
        end else begin
            unique case (st_q)
                PM_RUN: begin
                    if (sleep_stb) st_n = sel_q ? PM_STBY : PM_SLEEP;
                end
                PM_SLEEP: begin
                    if (ev.hit) begin
                        st_n    = PM_RUN;
                        wake_n  = 1'b1;
                        cause_n = ev.cause;
                    end
                end
                PM_STBY: begin
                    if (ev.hit) st_n = PM_SETTLE;
                end
                PM_SETTLE: begin
                    if (settle_done) begin
                        st_n    = PM_RUN;
                        wake_n  = 1'b1;
                        cause_n = WK_NMI;
                    end
                end
                default: st_n = PM_RUN;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (por) begin
            st_q       <= PM_RUN;
            sel_q      <= 1'b0;
            cpu_clk_en <= 1'b1;
            per_clk_en <= 1'b1;
            per_init   <= 1'b0;
            wake_req   <= 1'b0;
            cause_q    <= WK_IRQ;
        end else begin
            if (sel_we) sel_q <= sel_wd;
            st_q       <= st_n;
            cpu_clk_en <= (st_n == PM_RUN);
            per_clk_en <= (st_n == PM_RUN) || (st_n == PM_SLEEP);
            per_init   <= (st_q == PM_RUN) && (st_n == PM_STBY);
            wake_req   <= wake_n;
            cause_q    <= cause_n;
        end
    end

    assign stby_sel   = sel_q;
    assign wake_cause = cause_q;
endmodule

// File: rtl/pwr_mode_chk.sv
module pwr_mode_chk
    import pwr_mode_pkg::*;
#(
    parameter int LVL_W = 4
) (
    input logic             clk,
    input logic             por,
    input logic             mrst,
    input logic             sleep_stb,
    input logic             stby_sel,
    input logic             nmi,
    input logic             irq_req,
    input logic [LVL_W-1:0] irq_level,
    input logic [LVL_W-1:0] cpu_mask,
    input logic             irq_src_en,
    input logic             dma_addr_err,
    input logic             cpu_clk_en,
    input logic             per_clk_en,
    input logic             per_init,
    input logic             wake_req,
    input logic [1:0]       wake_cause,
    input pm_state_e        st
);
    assert_sleep_entry_R1: assert property (@(posedge clk) disable iff (por)
        cpu_clk_en && sleep_stb && !stby_sel && !mrst |=> !cpu_clk_en && per_clk_en && !per_init);

    assert_stby_entry_R2: assert property (@(posedge clk) disable iff (por)
        cpu_clk_en && sleep_stb && stby_sel && !mrst |=> !cpu_clk_en && !per_clk_en && per_init);

    assert_init_single_R2: assert property (@(posedge clk) disable iff (por)
        per_init |=> !per_init);

    assert_irq_masked_R3: assert property (@(posedge clk) disable iff (por)
        st == PM_SLEEP && irq_req && (!irq_src_en || irq_level <= cpu_mask)
        && !dma_addr_err && !nmi && !mrst |=> !cpu_clk_en && !wake_req);

    assert_stby_hold_R6: assert property (@(posedge clk) disable iff (por)
        st == PM_STBY && !nmi && !mrst |=> st == PM_STBY && !per_clk_en && !wake_req);

    assert_mrst_exit_R8: assert property (@(posedge clk) disable iff (por)
        mrst && !cpu_clk_en |=> cpu_clk_en && wake_req && wake_cause == 2'b11);

    assert_por_state_R9: assert property (@(posedge clk)
        por |=> cpu_clk_en && per_clk_en && !stby_sel && !wake_req && !per_init);

    assert_wake_single_R10: assert property (@(posedge clk) disable iff (por)
        wake_req |=> !wake_req);

    assert_clk_order_R10: assert property (@(posedge clk) disable iff (por)
        cpu_clk_en |-> per_clk_en);
endmodule

bind pwr_mode_ctrl pwr_mode_chk #(.LVL_W(LVL_W)) u_chk (
    .clk          (clk),
    .por          (por),
    .mrst         (mrst),
    .sleep_stb    (sleep_stb),
    .stby_sel     (stby_sel),
    .nmi          (nmi),
    .irq_req      (irq_req),
    .irq_level    (irq_level),
    .cpu_mask     (cpu_mask),
    .irq_src_en   (irq_src_en),
    .dma_addr_err (dma_addr_err),
    .cpu_clk_en   (cpu_clk_en),
    .per_clk_en   (per_clk_en),
    .per_init     (per_init),
    .wake_req     (wake_req),
    .wake_cause   (wake_cause),
    .st           (st_q)
);

// File: tb/tb_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_mode_ctrl;
    logic       clk = 1'b0;
    logic       por, mrst, sleep_stb, sel_we, sel_wd;
    logic       irq_req, irq_src_en, dma_addr_err, nmi;
    logic [3:0] irq_level, cpu_mask, settle_exp;
    logic       stby_sel, cpu_clk_en, per_clk_en, per_init, wake_req;
    logic [1:0] wake_cause;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    pwr_mode_ctrl dut (
        .clk(clk), .por(por), .mrst(mrst), .sleep_stb(sleep_stb),
        .sel_we(sel_we), .sel_wd(sel_wd), .irq_req(irq_req),
        .irq_level(irq_level), .cpu_mask(cpu_mask), .irq_src_en(irq_src_en),
        .dma_addr_err(dma_addr_err), .nmi(nmi), .settle_exp(settle_exp),
        .stby_sel(stby_sel), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
        .per_init(per_init), .wake_req(wake_req), .wake_cause(wake_cause)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        mrst = 0; sleep_stb = 0; sel_we = 0; sel_wd = 0;
        irq_req = 0; irq_src_en = 0; dma_addr_err = 0; nmi = 0;
        irq_level = 0; cpu_mask = 0;
    endtask

    // write the select bit, then strobe; returns just after the strobe edge
    task automatic enter_lp(input bit s);
        sel_we = 1; sel_wd = s;
        step();
        sel_we = 0;
        sleep_stb = 1;
        step();
        sleep_stb = 0;
    endtask

    task automatic mrst_exit(input bit s);
        mrst = 1;
        step();
        mrst = 0;
        chk("R8", "cpu_clk_en after mrst", int'(cpu_clk_en), 1);
        chk("R8", "wake_req after mrst", int'(wake_req), 1);
        chk("R8", "cause after mrst", int'(wake_cause), 3);
        chk("R8", "stby_sel kept", int'(stby_sel), int'(s));
        step();
    endtask

    function automatic int settle_len(input int k);
        int e;
        e = (k < 3) ? 3 : ((k > 12) ? 12 : k);
        return 1 << e;
    endfunction

    // -1 = no wake, else cause code
    function automatic int exp_wake(input bit s, input bit rq, input int lvl, input int msk,
                                    input bit en, input bit dma, input bit nm);
        if (s) return nm ? 2 : -1;
        if (nm) return 2;
        if (dma) return 1;
        if (rq && en && lvl > msk) return 0;
        return -1;
    endfunction

    task automatic await_run(input int exp_n);
        int n = 0;
        while (!cpu_clk_en && n < 5000) begin
            step();
            n++;
        end
        chk("R7", "settle cycles", n, exp_n);
        chk("R7", "per_clk_en after settle", int'(per_clk_en), 1);
        chk("R7", "wake_req after settle", int'(wake_req), 1);
        chk("R7", "cause after settle", int'(wake_cause), 2);
        step();
        chk("R10", "wake_req single cycle", int'(wake_req), 0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL R10 watchdog: actual 150000 cycles expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle();
        settle_exp = 0;
        por = 1;
        step(); step();
        por = 0;
        chk("R9", "cpu_clk_en after por", int'(cpu_clk_en), 1);
        chk("R9", "per_clk_en after por", int'(per_clk_en), 1);
        chk("R9", "stby_sel after por", int'(stby_sel), 0);
        chk("R9", "wake_req after por", int'(wake_req), 0);
        chk("R9", "per_init after por", int'(per_init), 0);

        // R11 select bit writes
        sel_we = 1; sel_wd = 1; step(); sel_we = 0;
        chk("R11", "stby_sel write 1", int'(stby_sel), 1);
        sel_we = 1; sel_wd = 0; step(); sel_we = 0;
        chk("R11", "stby_sel write 0", int'(stby_sel), 0);

        // R8 mrst in run: no wake
        mrst = 1; step(); mrst = 0;
        chk("R8", "no wake for mrst in run", int'(wake_req), 0);

        // R1 / R3 sleep and interrupt qualification
        enter_lp(0);
        chk("R1", "cpu_clk_en in sleep", int'(cpu_clk_en), 0);
        chk("R1", "per_clk_en in sleep", int'(per_clk_en), 1);
        chk("R1", "per_init in sleep", int'(per_init), 0);
        repeat (5) step();
        irq_req = 1; irq_src_en = 1; irq_level = 3; cpu_mask = 3;
        step();
        chk("R3", "equal level stays asleep", int'(cpu_clk_en), 0);
        irq_level = 2; step();
        chk("R3", "lower level stays asleep", int'(cpu_clk_en), 0);
        irq_level = 9; irq_src_en = 0; step();
        chk("R3", "disabled source stays asleep", int'(cpu_clk_en), 0);
        chk("R3", "no wake while masked", int'(wake_req), 0);
        irq_src_en = 1; step();
        idle();
        chk("R3", "irq wake cpu_clk_en", int'(cpu_clk_en), 1);
        chk("R3", "irq wake_req", int'(wake_req), 1);
        chk("R3", "irq cause", int'(wake_cause), 0);
        step();
        chk("R10", "wake_req single cycle", int'(wake_req), 0);

        // R4 DMA error beats interrupt
        enter_lp(0);
        repeat (5) step();
        dma_addr_err = 1; irq_req = 1; irq_src_en = 1; irq_level = 15; cpu_mask = 0;
        step(); idle();
        chk("R4", "dma wake_req", int'(wake_req), 1);
        chk("R4", "dma over irq cause", int'(wake_cause), 1);
        step();

        // R5 blanking in sleep
        enter_lp(0);
        nmi = 1;
        for (int i = 1; i <= 5; i++) begin
            step();
            chk("R5", "nmi blanked in sleep", int'(cpu_clk_en), 0);
        end
        dma_addr_err = 1;
        step(); idle();
        chk("R5", "nmi accepted after window", int'(cpu_clk_en), 1);
        chk("R4", "nmi over dma cause", int'(wake_cause), 2);
        step();

        // R2 / R5 / R6 / R7 standby
        settle_exp = 0;
        nmi = 1;
        enter_lp(1);
        chk("R2", "cpu_clk_en in standby", int'(cpu_clk_en), 0);
        chk("R2", "per_clk_en in standby", int'(per_clk_en), 0);
        chk("R2", "per_init on entry", int'(per_init), 1);
        step();
        chk("R2", "per_init one cycle", int'(per_init), 0);
        repeat (4) step();
        chk("R5", "nmi blanked in standby", int'(per_clk_en), 0);
        nmi = 0;
        irq_req = 1; irq_src_en = 1; irq_level = 15; cpu_mask = 0; dma_addr_err = 1;
        repeat (3) step();
        idle();
        chk("R6", "standby ignores irq/dma per_clk_en", int'(per_clk_en), 0);
        chk("R6", "standby ignores irq/dma wake_req", int'(wake_req), 0);
        nmi = 1; step(); nmi = 0;
        await_run(8);

        settle_exp = 15;
        enter_lp(1);
        repeat (5) step();
        nmi = 1; step(); nmi = 0;
        await_run(4096);

        // R8 mrst in standby, then por clears the bit
        enter_lp(1);
        repeat (2) step();
        mrst_exit(1);
        por = 1; step(); por = 0;
        chk("R9", "por clears stby_sel", int'(stby_sel), 0);

        // R12 strobe while asleep ignored
        enter_lp(0);
        sel_we = 1; sel_wd = 1; step(); sel_we = 0;
        sleep_stb = 1; step(); sleep_stb = 0;
        chk("R12", "second strobe keeps sleep", int'(per_clk_en), 1);
        chk("R12", "no per_init on second strobe", int'(per_init), 0);
        chk("R12", "cpu stays halted", int'(cpu_clk_en), 0);
        mrst_exit(1);

        // random trials
        for (int it = 0; it < 200; it++) begin
            bit s, rq, en, dma, nm;
            int lvl, msk, k, e;
            s   = 1'($urandom() % 2);
            k   = int'($urandom() % 6);
            rq  = 1'($urandom() % 2);
            en  = 1'($urandom() % 2);
            dma = ($urandom() % 4) == 0;
            nm  = ($urandom() % 4) == 0;
            lvl = int'($urandom() % 16);
            msk = int'($urandom() % 16);
            settle_exp = 4'(k);
            enter_lp(s);
            repeat (5) step();
            irq_req = rq; irq_src_en = en; dma_addr_err = dma; nmi = nm;
            irq_level = 4'(lvl); cpu_mask = 4'(msk);
            step(); idle();
            e = exp_wake(s, rq, lvl, msk, en, dma, nm);
            if (s == 0) begin
                chk("R3", "random sleep wake", int'(cpu_clk_en), (e >= 0) ? 1 : 0);
                if (e >= 0) begin
                    chk("R4", "random cause", int'(wake_cause), e);
                    step();
                end else begin
                    mrst_exit(s);
                end
            end else begin
                chk("R6", "random standby clocks off", int'(per_clk_en), 0);
                if (e >= 0) await_run(settle_len(k));
                else mrst_exit(s);
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule